// File: doc/BRIEF.md
# Fetch-Block Placement Cost Unit

This unit prices each instruction of an in-order issue model by where it sits inside a 32-byte fetch block. A decoded descriptor arrives with its byte address, a one-or-two-dword size flag, a base cycle count and three control flags. The flags say whether the instruction was reached by a forward jump, whether it is a conditional branch and, if so, whether that branch was taken. The unit works out the dword slot (address bits 4:2) and applies the placement rules. Wide instructions late in the block cost extra. Jump landings late in the block cost extra. Conditional branches late in the block cost extra when they fall through. A long-running instruction shields the dwords that follow it from the wide-instruction charge.

Every penalty unit costs a fixed number of cycles. The result is the base latency plus the penalty, reported one cycle after the descriptor is accepted, together with a running cycle total. A mask input zeroes every placement penalty, which models high occupancy hiding them. Decoding, fetching and executing the instruction are handled elsewhere.

Top module: `fetch_slot_penalty`

## Requirements
- R1: The slot is address bits 4:2. A two-dword instruction (`in_wide`=1) in slots 0 to 2 adds nothing. In slots 3 to 7 it adds one penalty unit, unless R5 exempts it. One unit is PEN_CYC cycles (default 4).
- R2: An instruction flagged as a forward-jump landing (`in_target`=1) adds nothing in slots 0 to 4. In slot N of 5 to 7 it adds N-4 units.
- R3: A conditional branch (`in_cbr`=1) that is not taken adds N-3 units in slot N of 4 to 7, and nothing in slots 0 to 3. A taken conditional branch adds no branch placement units.
- R4: For a conditional branch, `in_base` is ignored. The base is TAKEN_CYC (20) when taken and NTAKEN_CYC (4) when not taken.
- R5: An instruction whose effective base exceeds 4 opens a window of base/4 dwords. Each later instruction consumes its own size from the window. An instruction that starts while the window is non-zero pays no wide-instruction unit. A jump landing closes the window before it is priced.
- R6: A two-dword instruction of 16 or more cycles, followed by a two-dword instruction starting within the next 4 dwords, leaves the second one with no wide-instruction unit.
- R7: With `in_mask`=1 the penalty of that instruction is zero, and its cycles equal its effective base.
- R8: `out_valid` is high exactly in the cycle after a descriptor is accepted (`in_valid` and `in_ready`). `out_cycles` is then the effective base plus `out_pen`.
- R9: `out_total` starts at 0 and adds `out_cycles` on each `out_valid`, wrapping modulo 2^TOT_W. It holds in all other cycles.
- R10: While reset is asserted, `out_valid` and `in_ready` are 0 and `out_total` is 0. `in_ready` rises one clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Unit accepts a descriptor |
| in_addr | input | ADDR_W | Byte address of the instruction |
| in_wide | input | 1 | Instruction is two dwords |
| in_base | input | CYC_W | Base cycle count |
| in_target | input | 1 | Instruction was reached by a forward jump |
| in_cbr | input | 1 | Instruction is a conditional branch |
| in_taken | input | 1 | Conditional branch was taken |
| in_mask | input | 1 | Hide all placement penalties |
| out_valid | output | 1 | Result present |
| out_cycles | output | CYC_W+1 | Total cycles of the instruction |
| out_pen | output | PEN_W | Placement penalty in cycles |
| out_total | output | TOT_W | Running cycle total |

## Verification
The bench keeps every default except TOT_W, which it sets to 12. A random stream of a few hundred instructions can then carry the accumulator through several wraps, which the 32-bit default would never reach. With the default 8-bit base, instructions are long enough to open exemption windows of up to 63 dwords. The 16-cycle two-dword case and the window closing on jump landings are therefore both reachable.

// File: rtl/fetch_slot_penalty.sv
module fetch_slot_penalty #(
  parameter int ADDR_W     = 32,
  parameter int CYC_W      = 8,
  parameter int TOT_W      = 32,
  parameter int PEN_CYC    = 4,
  parameter int TAKEN_CYC  = 20,
  parameter int NTAKEN_CYC = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [ADDR_W-1:0]                    in_addr,
  input  logic                                 in_wide,
  input  logic [CYC_W-1:0]                     in_base,
  input  logic                                 in_target,
  input  logic                                 in_cbr,
  input  logic                                 in_taken,
  input  logic                                 in_mask,
  output logic                                 out_valid,
  output logic [CYC_W:0]                       out_cycles,
  output logic [$clog2(8*PEN_CYC+1)-1:0]       out_pen,
  output logic [TOT_W-1:0]                     out_total
);
  localparam int PEN_W     = $clog2(8*PEN_CYC+1);
  localparam int OUT_W     = CYC_W + 1;
  localparam int WIDE_FREE = 3;
  localparam int TGT_FREE  = 5;
  localparam int CBR_FREE  = 4;

  logic             rdy_q;
  logic [CYC_W-1:0] win_q, win_in, win_nxt, eff_base;
  logic [2:0]       slot;
  logic [3:0]       u_wide, u_tgt, u_cbr, units;
  logic [PEN_W-1:0] pen;
  logic [1:0]       sz;
  logic             accept;

  assign in_ready = rdy_q;
  assign accept   = in_valid && rdy_q;
  assign slot     = in_addr[4:2];
  assign sz       = in_wide ? 2'd2 : 2'd1;

  assign eff_base = !in_cbr ? in_base :
                    in_taken ? CYC_W'(TAKEN_CYC) : CYC_W'(NTAKEN_CYC);

  assign win_in = in_target ? '0 : win_q;

  assign u_wide = (in_wide && 32'(slot) >= WIDE_FREE && win_in == '0) ? 4'd1 : 4'd0;
  assign u_tgt  = (in_target && 32'(slot) >= TGT_FREE)
                  ? 4'({1'b0, slot} - 4'(TGT_FREE - 1)) : 4'd0;
  assign u_cbr  = (in_cbr && !in_taken && 32'(slot) >= CBR_FREE)
                  ? 4'({1'b0, slot} - 4'(CBR_FREE - 1)) : 4'd0;
  assign units  = u_wide + u_tgt + u_cbr;
  assign pen    = in_mask ? '0 : PEN_W'(PEN_W'(units) * PEN_W'(PEN_CYC));

  always_comb begin
    if (eff_base > CYC_W'(4))
      win_nxt = eff_base >> 2;
    else if (win_in > CYC_W'(sz))
      win_nxt = win_in - CYC_W'(sz);
    else
      win_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      win_q      <= '0;
      out_valid  <= 1'b0;
      out_cycles <= '0;
      out_pen    <= '0;
      out_total  <= '0;
    end else begin
      rdy_q     <= 1'b1;
      out_valid <= accept;
      if (accept) begin
        win_q      <= win_nxt;
        out_pen    <= pen;
        out_cycles <= OUT_W'(eff_base) + OUT_W'(pen);
        out_total  <= out_total + TOT_W'(OUT_W'(eff_base) + OUT_W'(pen));
      end
    end
  end
endmodule

// File: rtl/fetch_slot_penalty_chk.sv
module fetch_slot_penalty_chk #(
  parameter int CYC_W   = 8,
  parameter int TOT_W   = 32,
  parameter int PEN_CYC = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           in_valid,
  input logic                           in_ready,
  input logic                           in_mask,
  input logic                           out_valid,
  input logic [CYC_W:0]                 out_cycles,
  input logic [$clog2(8*PEN_CYC+1)-1:0] out_pen,
  input logic [TOT_W-1:0]               out_total
);
  p_valid_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);
  p_cycles_cover_pen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> 32'(out_cycles) >= 32'(out_pen));
  p_total_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_total == TOT_W'($past(out_total) + TOT_W'(out_cycles)));
  p_total_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_total));
  p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_mask && in_valid && in_ready)) |-> out_pen == '0);
  p_pen_quantum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_pen) % PEN_CYC == 0 && 32'(out_pen) <= 8*PEN_CYC));
endmodule

bind fetch_slot_penalty fetch_slot_penalty_chk #(
  .CYC_W(CYC_W), .TOT_W(TOT_W), .PEN_CYC(PEN_CYC)
) u_chk (.*);

// File: tb/sim_fetch_slot_penalty.sv
module sim_fetch_slot_penalty;
  localparam int TW = 12;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_wide = 0, in_target = 0, in_cbr = 0, in_taken = 0, in_mask = 0;
  logic [31:0] in_addr = 0;
  logic [7:0]  in_base = 0;
  logic        in_ready, out_valid;
  logic [8:0]  out_cycles;
  logic [5:0]  out_pen;
  logic [TW-1:0] out_total;

  fetch_slot_penalty #(.TOT_W(TW)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, mwin = 0, mtot = 0;
  bit done = 0;
  bit e_v = 0; int e_cyc = 0, e_pen = 0; string e_tag = "R10";

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int a, bit w, int b, bit t, bit c, bit k, bit m, string tag);
    int eb, slot, w0, u, sz;
    chk({e_tag, " R8 valid"}, int'(out_valid), int'(e_v));
    if (e_v) begin
      chk({e_tag, " pen"}, int'(out_pen), e_pen);
      chk({e_tag, " R8 cycles"}, int'(out_cycles), e_cyc);
    end
    chk({e_tag, " R9 total"}, int'(out_total), mtot);
    if (v) chk("R10 ready", int'(in_ready), 1);
    in_valid = v; in_addr = a; in_wide = w; in_base = 8'(b);
    in_target = t; in_cbr = c; in_taken = k; in_mask = m;
    e_v = v; e_tag = tag;
    if (v) begin
      eb = c ? (k ? 20 : 4) : b;
      slot = (a >> 2) & 7;
      w0 = t ? 0 : mwin;
      sz = w ? 2 : 1;
      u = 0;
      if (w && slot >= 3 && w0 == 0) u += 1;
      if (t && slot >= 5) u += slot - 4;
      if (c && !k && slot >= 4) u += slot - 3;
      e_pen = m ? 0 : u * 4;
      e_cyc = eb + e_pen;
      mtot = (mtot + e_cyc) % (1 << TW);
      mwin = (eb > 4) ? eb / 4 : (w0 > sz ? w0 - sz : 0);
    end
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(out_valid), 0);
    chk("R10 reset ready", int'(in_ready), 0);
    chk("R10 reset total", int'(out_total), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready after reset", int'(in_ready), 1);
    // R1: wide instruction in every slot
    for (int s = 0; s < 8; s++) step(1, 32'h100 + s*4, 1, 4, 0, 0, 0, 0, "R1 wide slot");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8 idle");
    // R2: jump landings in every slot
    for (int s = 0; s < 8; s++) step(1, 32'h200 + s*4, 0, 4, 1, 0, 0, 0, "R2 target slot");
    // R3 / R4: conditional branches, in_base ignored
    for (int s = 0; s < 8; s++) step(1, 32'h300 + s*4, 0, 99, 0, 1, 0, 0, "R3 R4 cbr not taken");
    for (int s = 0; s < 8; s++) step(1, 32'h400 + s*4, 0, 99, 1, 1, 1, 0, "R3 R4 cbr taken");
    // R5: window from a 12-cycle instruction, then closed by a landing
    step(1, 32'h500, 0, 12, 0, 0, 0, 0, "R5 opener");
    step(1, 32'h504, 0, 4, 0, 0, 0, 0, "R5 narrow");
    step(1, 32'h514, 1, 4, 0, 0, 0, 0, "R5 wide exempt");
    step(1, 32'h51C, 1, 4, 0, 0, 0, 0, "R5 wide after window");
    step(1, 32'h600, 0, 12, 0, 0, 0, 0, "R5 opener");
    step(1, 32'h60C, 1, 4, 1, 0, 0, 0, "R5 landing closes window");
    // R6: long wide then wide within 4 dwords
    step(1, 32'h708, 1, 16, 0, 0, 0, 0, "R6 long wide");
    step(1, 32'h710, 1, 4, 0, 0, 0, 0, "R6 second wide free");
    step(1, 32'h718, 1, 4, 0, 0, 0, 0, "R6 third wide");
    // R7: mask on worst-case placement
    step(1, 32'h81C, 1, 4, 1, 1, 0, 1, "R7 masked");
    step(1, 32'h81C, 1, 4, 1, 1, 0, 0, "R7 unmasked");
    // R9: random stream with gaps, wraps the 12-bit total
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 3) != 0, $urandom, $urandom_range(0, 1),
           $urandom_range(0, 255), $urandom_range(0, 3) == 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 1),
           $urandom_range(0, 7) == 0, "R9 random");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8 flush");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 hold");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule